// File: doc/BRIEF.md
# Power-Fail Autostore and Recall Controller

This controller sits beside a nonvolatile-backed SRAM and decides when the contents must be copied into the nonvolatile array (a store) and when the nonvolatile copy must be loaded back (a recall). It receives two digital supply indications from external comparators. One says the supply has fallen below the switch threshold. The other says it has fallen below the deeper reset threshold. Both arrive asynchronously and are resynchronised inside the block.

A dirty flag records whether any SRAM write has been accepted since the last completed transfer. When the supply starts to fail, a store is requested only if the array is dirty. A software store decoded elsewhere is always honoured, provided the supply is good. A dip below the reset level arms a recall, which is issued once the supply is back above the switch threshold. A shallow brownout leaves the SRAM contents in place and issues no recall.

While the supply is low, or while a transfer is running, the block raises a write-inhibit signal. The transfer engine acknowledges the end of a store or recall with a one-cycle done pulse. A recall is also closed by a cycle limit when no acknowledge arrives.

Top module: `pfail_nv_ctrl`

## Requirements
- R1: Each supply indication passes through a two-stage synchroniser. When `sup_low_a` rises, `wr_inhibit` rises on the second rising clock edge.
- R2: On a rising transition of the synchronised below-switch indication, `store_req` rises one clock later, provided at least one SRAM write has been accepted since the last completed store or recall.
- R3: When no write has been accepted since the last completed transfer, a falling supply produces no store request.
- R4: A one-cycle `sw_store_req` pulse while the supply is good and the block is idle raises `store_req` on the next edge, whether or not the array is dirty.
- R5: While the synchronised supply is below the switch threshold, `sw_store_req` is ignored and `sram_wr_req` does not mark the array dirty.
- R6: An accepted write (`sram_wr_req` high while `wr_inhibit` is low) marks the array dirty. Completion of a store or a recall clears the mark.
- R7: A synchronised below-reset indication latches a pending recall. The block starts that recall (`recall_req` high) once the synchronised supply is above the switch threshold and the block is idle.
- R8: A brownout in which the below-reset indication never asserts produces no recall.
- R9: `recall_req` stays high until `xfer_done` arrives or for at most `RECALL_MAX_CYC` cycles. `store_req` stays high until `xfer_done`.
- R10: Reset arms a pending recall. During reset, `store_req` and `recall_req` are low and `wr_inhibit` is high. After release with a good supply, `recall_req` rises on the third edge.
- R11: `store_req` and `recall_req` are never high together. `wr_inhibit` is high whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_low_a | input | 1 | Supply below switch threshold (asynchronous) |
| sup_dead_a | input | 1 | Supply below reset threshold (asynchronous) |
| sram_wr_req | input | 1 | SRAM write attempt in this cycle |
| sw_store_req | input | 1 | One-cycle software store request |
| xfer_done | input | 1 | Transfer engine finished the current store or recall |
| store_req | output | 1 | Store in progress request to the transfer engine |
| recall_req | output | 1 | Recall in progress request to the transfer engine |
| wr_inhibit | output | 1 | SRAM writes blocked |

## Verification
The hardest case to reach is a pending recall that coexists with a dirty array. The supply falls with both indications asserted, so a store must run first, while the recall waits for the supply to return. The bench first makes an accepted write, then asserts both indications in the same cycle. It acknowledges the resulting store and then releases both indications together. It checks that the recall starts on the third edge and that the recall closes by its cycle limit. It also checks that the dirty mark was cleared, by failing the supply again and seeing no store.

// File: rtl/pfail_nv_ctrl.sv
module pfail_nv_ctrl #(
  parameter int RECALL_MAX_CYC = 55000,
  localparam int CW = $clog2(RECALL_MAX_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_low_a,
  input  logic sup_dead_a,
  input  logic sram_wr_req,
  input  logic sw_store_req,
  input  logic xfer_done,
  output logic store_req,
  output logic recall_req,
  output logic wr_inhibit
);

  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_RECALL} st_t;

  st_t           state, state_nx;
  logic [1:0]    low_sync, dead_sync;
  logic          low_s, dead_s, low_d;
  logic          dirty, recall_pend;
  logic [CW-1:0] rc_cnt;
  logic          low_edge, wr_ok, xfer_end, rc_limit;

  assign low_s  = low_sync[1];
  assign dead_s = dead_sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      low_sync  <= 2'b11;
      dead_sync <= 2'b11;
      low_d     <= 1'b1;
    end else begin
      low_sync  <= {low_sync[0], sup_low_a};
      dead_sync <= {dead_sync[0], sup_dead_a};
      low_d     <= low_s;
    end

  assign low_edge   = low_s & ~low_d;
  assign store_req  = (state == ST_STORE);
  assign recall_req = (state == ST_RECALL);
  assign wr_inhibit = low_s | store_req | recall_req;
  assign wr_ok      = sram_wr_req & ~wr_inhibit;
  assign rc_limit   = (rc_cnt == CW'(RECALL_MAX_CYC - 1));
  assign xfer_end   = (store_req & xfer_done) | (recall_req & (xfer_done | rc_limit));

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:
        if (low_edge && dirty)            state_nx = ST_STORE;
        else if (!low_s && recall_pend)   state_nx = ST_RECALL;
        else if (!low_s && sw_store_req)  state_nx = ST_STORE;
      ST_STORE:  if (xfer_end) state_nx = ST_IDLE;
      ST_RECALL: if (xfer_end) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= ST_IDLE;
      dirty       <= 1'b0;
      recall_pend <= 1'b1;
      rc_cnt      <= '0;
    end else begin
      state <= state_nx;
      if (xfer_end)   dirty <= 1'b0;
      else if (wr_ok) dirty <= 1'b1;
      if (dead_s) recall_pend <= 1'b1;
      else if (state == ST_IDLE && state_nx == ST_RECALL) recall_pend <= 1'b0;
      if (state != ST_RECALL) rc_cnt <= '0;
      else                    rc_cnt <= rc_cnt + 1'b1;
    end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req)); // R11
  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_wr_req && !wr_inhibit) |=> dirty); // R6
  AST_STORE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_req) |-> $past(dirty || sw_store_req)); // R3
  AST_RECALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recall_req) |-> $past(recall_pend)); // R7
  AST_RECALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> (rc_cnt < CW'(RECALL_MAX_CYC))); // R9
  AST_STORE_CLEANS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(store_req) |-> !dirty); // R6

endmodule

// File: tb/pfail_nv_ctrl_tb_top.sv
module pfail_nv_ctrl_tb_top;
  localparam int RMAX = 20;

  logic clk = 0, rst_n = 0;
  logic sup_low_a = 0, sup_dead_a = 0, sram_wr_req = 0, sw_store_req = 0, xfer_done = 0;
  logic store_req, recall_req, wr_inhibit;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  pfail_nv_ctrl #(.RECALL_MAX_CYC(RMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .sup_low_a(sup_low_a), .sup_dead_a(sup_dead_a),
    .sram_wr_req(sram_wr_req), .sw_store_req(sw_store_req), .xfer_done(xfer_done),
    .store_req(store_req), .recall_req(recall_req), .wr_inhibit(wr_inhibit));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_done();
    xfer_done = 1; edges(1); xfer_done = 0;
  endtask

  task automatic write_once();
    sram_wr_req = 1; edges(1); sram_wr_req = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(store_req, 0, "R10 store low in reset");
    chk(recall_req, 0, "R10 recall low in reset");
    chk(wr_inhibit, 1, "R10 inhibit high in reset");
    rst_n = 1;
    edges(2);
    chk(recall_req, 0, "R10 no recall before third edge");
    edges(1);
    chk(recall_req, 1, "R10 power-up recall");
    chk(wr_inhibit, 1, "R11 inhibit during recall");
    pulse_done();
    chk(recall_req, 0, "R9 recall ends on done");
    edges(2);
  endtask

  task automatic t_clean_brownout();
    sup_low_a = 1;
    edges(1);
    chk(wr_inhibit, 0, "R1 inhibit not yet after one edge");
    edges(1);
    chk(wr_inhibit, 1, "R1 inhibit after two edges");
    edges(4);
    chk(store_req, 0, "R3 clean array not stored");
    sup_low_a = 0;
    edges(6);
    chk(recall_req, 0, "R8 shallow brownout gives no recall");
    chk(wr_inhibit, 0, "R1 inhibit released");
  endtask

  task automatic t_dirty_store();
    write_once();
    sup_low_a = 1;
    edges(2);
    chk(store_req, 0, "R2 store not before third edge");
    edges(1);
    chk(store_req, 1, "R2 dirty array stored on supply fall");
    chk(recall_req, 0, "R11 exclusive");
    edges(3);
    chk(store_req, 1, "R9 store held until done");
    pulse_done();
    chk(store_req, 0, "R9 store ends on done");
    sup_low_a = 0; edges(4);
    sup_low_a = 1; edges(5);
    chk(store_req, 0, "R6 store cleared dirty mark");
    sup_low_a = 0; edges(4);
  endtask

  task automatic t_sw_store();
    sw_store_req = 1; edges(1); sw_store_req = 0;
    chk(store_req, 1, "R4 software store on clean array");
    chk(wr_inhibit, 1, "R11 inhibit during store");
    pulse_done();
    chk(store_req, 0, "R4 software store completes");
  endtask

  task automatic t_inhibit();
    sup_low_a = 1; edges(3);
    write_once();
    sw_store_req = 1; edges(1); sw_store_req = 0;
    edges(2);
    chk(store_req, 0, "R5 software store ignored while low");
    sup_low_a = 0; edges(4);
    sup_low_a = 1; edges(5);
    chk(store_req, 0, "R5 write while low not marked dirty");
    sup_low_a = 0; edges(4);
  endtask

  task automatic t_deep();
    int hi = 0;
    write_once();
    sup_low_a = 1; sup_dead_a = 1;
    edges(3);
    chk(store_req, 1, "R2 store before deep loss");
    pulse_done();
    edges(3);
    chk(recall_req, 0, "R7 recall waits for supply");
    sup_low_a = 0; sup_dead_a = 0;
    edges(2);
    chk(recall_req, 0, "R7 recall not before third edge");
    edges(1);
    chk(recall_req, 1, "R7 recall after supply returns");
    for (int i = 0; i < RMAX + 10; i++) begin
      if (recall_req) hi++;
      edges(1);
    end
    n_chk++;
    if (hi != RMAX) begin
      n_err++;
      $display("FAIL R9 recall length: actual=%0d expected=%0d", hi, RMAX);
    end
    sup_low_a = 1; edges(5);
    chk(store_req, 0, "R6 clean after recall");
    sup_low_a = 0; edges(4);
  endtask

  initial begin
    #1500000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_clean_brownout();
    t_dirty_store();
    t_sw_store();
    t_inhibit();
    t_deep();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule